// File: doc/BRIEF.md
# SD Command Frame Transmitter

This block sends one command frame at a time to an SD card over the single CMD wire. A processor writes the 32-bit argument as four byte registers, then writes the command index. That index write starts the transfer. The block latches a 48-bit frame, shifts it out most significant bit first, and computes the CRC7 checksum serially while the first 40 bits go out. The checksum and the closing bit follow with no gap. The CMD wire is open-drain: the block only ever pulls it low, and an internal pull-up supplies every 1. The block also produces the card clock by dividing the system clock. Each outgoing bit changes on a falling card-clock edge, so it is steady when the card samples on the rising edge.

The controller is a state machine with six named states:

| State | Role |
|---|---|
| ST_IDLE | Line released. A trigger write loads the frame and moves to ST_ARM. |
| ST_ARM | At the next falling card-clock edge, emits the start bit, takes the first CRC step and moves to ST_HDR. |
| ST_HDR | Emits one header or argument bit per falling edge. After the 40th bit it moves to ST_CRC. |
| ST_CRC | Emits the seven checksum bits. After the last one it moves to ST_ENDB. |
| ST_ENDB | Emits the closing 1 and moves to ST_DONE. |
| ST_DONE | Holds that bit for one more card-clock period, then moves to ST_IDLE at the next falling edge. |

Top module: `sdcmd_frame_tx`

## Requirements
- R1: A frame is 48 bits sent MSB first: a 0, then a 1, then the 6-bit index, the 32-bit argument (bit 31 first), the 7-bit CRC, and a final 1.
- R2: The CRC7 uses the polynomial x^7+x^3+1 and starts from zero at the start bit. It covers the first 40 frame bits. For example, index 0 with argument 0 gives CRC 7'h4A, and index 8 with argument 0x000001AA gives CRC 7'h43.
- R3: Register addresses are 0 to 3 for argument bytes (address 0 = bits 7:0, address 3 = bits 31:24), 4 for the command index and 5 for status (bit 0 = busy). Reads return the stored values, and unused bits and addresses read as 0. After reset everything reads 0.
- R4: A write to address 4 while idle launches a frame. The frame uses the argument held at that moment and the low 6 bits of the written byte.
- R5: The index register keeps only wdata[5:0], and its bits 7:6 read back as 0.
- R6: cmd_pull_low is 1 only while a 0 bit is on the line. It is 0 whenever the block is idle and after reset.
- R7: sd_clk runs continuously with a period of 2*HALF_DIV system clocks (2 by default, which is half the system rate).
- R8: cmd_pull_low changes only in the system cycle in which sd_clk falls.
- R9: busy goes to 1 the cycle after an accepted trigger write. It stays 1 until the closing 1 has been held for a full sd_clk period, then returns to 0.
- R10: While busy, a write to address 4 is ignored: no new frame starts and the index register is unchanged. Argument writes while busy update the argument registers but do not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data, combinational from reg_addr |
| sd_clk | output | 1 | Card clock |
| cmd_pull_low | output | 1 | Drives CMD low when 1; released when 0 |
| busy | output | 1 | Frame in progress |

## Verification
Two things can happen in the same system cycle: an index write can arrive in the last busy cycle, while the controller is leaving ST_DONE, and a new frame may also be accepted at that point. The bench provokes this by holding the index write strobe high for the whole transfer and releasing it only once busy has dropped and risen again. The scoreboard must then see exactly one further frame, with the new index, and no frame started by the writes made during the transfer. A monitor takes the CMD bit at each rising sd_clk edge, assembles each 48-bit frame and compares it with the queued expected frame. That expected frame is built from the requirements, with fixed CRC values as anchors.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam int FRAME_W      = 48;
    localparam int CRC_W        = 7;
    localparam int PRE_CRC_BITS = 40;
    localparam int CNT_W        = $clog2(FRAME_W + 1);
    localparam int ARG_BYTES    = 4;
    localparam int IDX_W        = 6;
    localparam int ADDR_W       = 3;

    localparam logic [ADDR_W-1:0] ADDR_IDX  = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd5;

    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_HDR,
        ST_CRC,
        ST_ENDB,
        ST_DONE
    } tx_state_e;
endpackage

// File: rtl/sdcmd_clkdiv.sv
module sdcmd_clkdiv #(
    parameter int HALF_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic sd_clk,
    output logic fall_tick
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

    logic [DW-1:0] div_q;
    logic          term;

    assign term      = (div_q == LAST);
    assign fall_tick = term && sd_clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            sd_clk <= 1'b0;
        end else if (term) begin
            div_q  <= '0;
            sd_clk <= ~sd_clk;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] stepped;
    logic             fb;

    always_comb begin
        base    = clear ? '0 : crc;
        fb      = din ^ base[CRC_W-1];
        stepped = {base[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc <= '0;
        else if (step)  crc <= stepped;
        else if (clear) crc <= '0;
    end
endmodule

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
    import sdcmd_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [7:0]                wdata,
    input  logic                      busy,
    output logic [8*ARG_BYTES-1:0]    arg,
    output logic [IDX_W-1:0]          idx,
    output logic                      launch,
    output logic [7:0]                rd_data
);
    assign launch = wr_en && (addr == ADDR_IDX) && !busy;

    for (genvar b = 0; b < ARG_BYTES; b++) begin : g_arg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                arg[8*b +: 8] <= '0;
            else if (wr_en && addr == ADDR_W'(b))
                arg[8*b +: 8] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx <= '0;
        else if (launch) idx <= wdata[IDX_W-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (int'(addr) < ARG_BYTES)
            rd_data = arg[8*addr +: 8];
        else if (addr == ADDR_IDX)
            rd_data = {{(8-IDX_W){1'b0}}, idx};
        else if (addr == ADDR_STAT)
            rd_data = {7'd0, busy};
    end
endmodule

// File: rtl/sdcmd_frame_tx.sv
module sdcmd_frame_tx
    import sdcmd_pkg::*;
#(
    parameter int HALF_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rd_data,
    output logic              sd_clk,
    output logic              cmd_pull_low,
    output logic              busy
);
    tx_state_e          state_q, state_d;
    logic               fall_tick;
    logic               launch;
    logic [31:0]        arg;
    logic [IDX_W-1:0]   idx_q;
    logic [FRAME_W-1:0] frame_sr;
    logic [CNT_W-1:0]   bit_cnt;
    logic               tx_bit;
    logic [CRC_W-1:0]   crc_val;
    logic               crc_step;
    logic [2:0]         crc_pos;
    logic               emit_hdr;

    assign busy         = (state_q != ST_IDLE);
    assign cmd_pull_low = ~tx_bit;
    assign emit_hdr     = fall_tick && (state_q == ST_ARM || state_q == ST_HDR);
    assign crc_step     = emit_hdr;
    assign crc_pos      = 3'(bit_cnt - CNT_W'(PRE_CRC_BITS));

    sdcmd_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .sd_clk    (sd_clk),
        .fall_tick (fall_tick)
    );

    sdcmd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .busy    (busy),
        .arg     (arg),
        .idx     (idx_q),
        .launch  (launch),
        .rd_data (reg_rd_data)
    );

    sdcmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .step  (crc_step),
        .din   (frame_sr[FRAME_W-1]),
        .crc   (crc_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)    state_d = ST_ARM;
            ST_ARM:  if (fall_tick) state_d = ST_HDR;
            ST_HDR:  if (fall_tick && bit_cnt == CNT_W'(PRE_CRC_BITS - 1))
                                    state_d = ST_CRC;
            ST_CRC:  if (fall_tick && bit_cnt == CNT_W'(FRAME_W - 2))
                                    state_d = ST_ENDB;
            ST_ENDB: if (fall_tick) state_d = ST_DONE;
            ST_DONE: if (fall_tick) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // line, shifter and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_sr <= '0;
            bit_cnt  <= '0;
            tx_bit   <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    tx_bit <= 1'b1;
                    if (launch) begin
                        frame_sr <= {1'b0, 1'b1, reg_wdata[IDX_W-1:0], arg,
                                     {(CRC_W+1){1'b0}}};
                        bit_cnt  <= '0;
                    end
                end
                ST_ARM, ST_HDR: if (fall_tick) begin
                    tx_bit   <= frame_sr[FRAME_W-1];
                    frame_sr <= {frame_sr[FRAME_W-2:0], 1'b0};
                    bit_cnt  <= bit_cnt + 1'b1;
                end
                ST_CRC: if (fall_tick) begin
                    tx_bit  <= crc_val[3'(CRC_W - 1) - crc_pos];
                    bit_cnt <= bit_cnt + 1'b1;
                end
                ST_ENDB: if (fall_tick) begin
                    tx_bit  <= 1'b1;
                    bit_cnt <= bit_cnt + 1'b1;
                end
                ST_DONE: tx_bit <= 1'b1;
                default: tx_bit <= 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_frame_tx_chk.sv
module sdcmd_frame_tx_chk
    import sdcmd_pkg::*;
#(
    parameter int HALF_DIV = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [2:0]       reg_addr,
    input logic             busy,
    input logic             sd_clk,
    input logic             cmd_pull_low,
    input logic [IDX_W-1:0] idx_q
);
    localparam int GW = $clog2(HALF_DIV + 2);
    logic [GW-1:0] since_toggle;
    logic          sd_clk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_toggle <= '0;
            sd_clk_d     <= 1'b0;
        end else begin
            sd_clk_d     <= sd_clk;
            since_toggle <= (sd_clk != sd_clk_d) ? GW'(1) : since_toggle + 1'b1;
        end
    end

    // R8: the line moves only with a falling card clock
    p_line_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_pull_low) |-> $fell(sd_clk));

    // R9: busy rises only after a trigger write
    p_busy_from_trigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr_en && reg_addr == ADDR_IDX));

    // R6: released whenever idle
    p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_pull_low);

    // R10: index writes during a transfer leave the index alone
    p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr_en && reg_addr == ADDR_IDX) |=> $stable(idx_q));

    // R7: card clock never stalls longer than a half period
    p_clk_half_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        since_toggle <= GW'(HALF_DIV));
endmodule

bind sdcmd_frame_tx sdcmd_frame_tx_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .busy         (busy),
    .sd_clk       (sd_clk),
    .cmd_pull_low (cmd_pull_low),
    .idx_q        (idx_q)
);

// File: tb/sdcmd_frame_tx_tb.sv
module sdcmd_frame_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rd_data;
    logic       sd_clk, cmd_pull_low, busy;

    int checks = 0;
    int failures = 0;
    int frames_seen = 0;
    int frames_sent = 0;
    bit done = 1'b0;
    logic [47:0] expq[$];

    always #10 clk = ~clk;

    sdcmd_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data), .sd_clk(sd_clk),
        .cmd_pull_low(cmd_pull_low), .busy(busy)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7_ref(input logic [39:0] bits);
        logic [6:0] c = 7'd0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = bits[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [47:0] mk_frame(input logic [5:0] ix, input logic [31:0] a);
        logic [39:0] hdr = {2'b01, ix, a};
        return {hdr, crc7_ref(hdr), 1'b1};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rd_data;
    endtask

    task automatic wait_idle();
        do begin @(posedge clk); #3; end while (busy);
        @(posedge clk); #1;
    endtask

    // driver: loads argument, pushes expected frame, triggers
    task automatic send(input logic [7:0] ixw, input logic [31:0] a, input logic [47:0] exp);
        for (int b = 0; b < 4; b++) wr(3'(b), a[8*b +: 8]);
        expq.push_back(exp);
        frames_sent++;
        wr(3'd4, ixw);
    endtask

    // monitor: assembles frames at rising card clock and scores them
    initial begin
        logic prev_clk = 1'b0;
        logic prev_line = 1'b0;
        logic [47:0] acc;
        int nbits = 0;
        forever begin
            @(posedge clk); #2;
            if (rst_n) begin
                if (cmd_pull_low !== prev_line)
                    check("R8 line change on falling sd_clk", {62'd0, prev_clk, sd_clk}, 64'h2);
                if (sd_clk && !prev_clk) begin
                    if (nbits > 0 || cmd_pull_low) begin
                        acc = {acc[46:0], ~cmd_pull_low};
                        nbits++;
                        if (nbits == 48) begin
                            frames_seen++;
                            if (expq.size() == 0)
                                check("R10 unexpected frame", {16'd0, acc}, 64'd0);
                            else
                                check("R1 frame", {16'd0, acc}, {16'd0, expq.pop_front()});
                            nbits = 0;
                        end
                    end
                end
            end
            prev_clk = sd_clk;
            prev_line = cmd_pull_low;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int t0, t1;
        repeat (3) @(posedge clk); #1;
        // reset state (R3, R6)
        check("R6 reset released", {63'd0, cmd_pull_low}, 64'd0);
        check("R9 reset not busy", {63'd0, busy}, 64'd0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R3 reset read zero", {56'd0, d}, 64'd0);
        end
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R7: card clock period
        t0 = 0; t1 = 0;
        for (int c = 0; c < 12; c++) begin
            @(posedge clk); #2;
            if (sd_clk && t0 == 0) t0 = c + 1;
            else if (sd_clk && t0 != 0 && t1 == 0 && c + 1 > t0 + 1) t1 = c + 1;
        end
        check("R7 sd_clk period", 64'(t1 - t0), 64'd2);

        // R2 anchors: fixed CRC values
        send(8'h00, 32'h0, 48'h400000000095);
        wait_idle();
        send(8'hC8, 32'h000001AA, 48'h48000001AA87);   // R5 upper bits dropped
        #1;
        rd(3'd5, d);
        check("R3 R9 status busy", {56'd0, d}, 64'd1);
        wait_idle();
        rd(3'd4, d);
        check("R5 index readback", {56'd0, d}, 64'h08);
        rd(3'd0, d); check("R3 arg byte0", {56'd0, d}, 64'hAA);
        rd(3'd1, d); check("R3 arg byte1", {56'd0, d}, 64'h01);
        rd(3'd3, d); check("R3 arg byte3", {56'd0, d}, 64'h00);
        rd(3'd6, d); check("R3 unused addr", {56'd0, d}, 64'h00);

        // R4 further patterns
        send(8'h3F, 32'hFFFFFFFF, mk_frame(6'h3F, 32'hFFFFFFFF));
        wait_idle();
        send(8'h11, 32'hA5C30F1E, mk_frame(6'h11, 32'hA5C30F1E));
        repeat (20) @(posedge clk); #1;
        // R10: trigger and argument write during transfer
        wr(3'd4, 8'h3F);
        wr(3'd0, 8'h77);
        check("R9 busy during frame", {63'd0, busy}, 64'd1);
        wait_idle();
        rd(3'd4, d); check("R10 index unchanged", {56'd0, d}, 64'h11);
        rd(3'd0, d); check("R10 arg write accepted", {56'd0, d}, 64'h77);
        check("R10 one frame only", 64'(frames_seen), 64'(frames_sent));
        check("R9 busy low after end", {63'd0, busy}, 64'd0);

        // same-cycle case: index strobe held through the busy-to-idle edge
        send(8'h05, 32'h12345678, mk_frame(6'h05, 32'h12345678));
        repeat (10) @(posedge clk); #1;
        expq.push_back(mk_frame(6'h29, 32'h12345678));
        frames_sent++;
        reg_addr = 3'd4; reg_wdata = 8'h29; reg_wr_en = 1'b1;
        begin
            bit seen_low = 1'b0;
            forever begin
                @(posedge clk); #1;
                if (!busy) seen_low = 1'b1;
                else if (seen_low) break;
            end
        end
        reg_wr_en = 1'b0;
        wait_idle();
        repeat (6) @(posedge clk); #1;
        check("R4 R10 back-to-back frames", 64'(frames_seen), 64'(frames_sent));
        check("R1 queue drained", 64'(expq.size()), 64'd0);
        rd(3'd4, d); check("R4 relaunched index", {56'd0, d}, 64'h29);
        check("R6 idle released", {63'd0, cmd_pull_low}, 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule